// File: doc/BRIEF.md
# Port Pin Change Detector

This block watches the upper half of an 8-bit input port and reports when a watched pin differs from a reference copy of the port. The reference copy is not the previous cycle's value. It is a snapshot that is captured whenever software reads the port. Any watched pin that is configured as an input and differs from its snapshot bit sets one sticky change flag. That flag drives an interrupt request, gated by an enable, and a wake request that does not depend on the enable.

Software handles the event in two steps. First it reads the port, which takes a new snapshot and removes the difference. Then it clears the flag. If the flag is cleared before the read, the clear has no effect, because the difference still exists and sets the flag again on every cycle. Pin levels reach the block already synchronized.

Top module: `port_change_ioc`

## Requirements
- R1: While `rst_ni` is low, `flag_o`, `irq_o` and `wake_o` are 0.
- R2: On the first clock edge after reset is released, the snapshot is loaded from `pins_i`. Whatever those pin values are, pins held steady after reset never set the flag.
- R3: A pin in bits 7 to 4 whose `dir_i` bit is 1 (input) and whose level differs from its snapshot bit sets `flag_o` at the next clock edge.
- R4: Pins 3 to 0 never set the flag, whatever their levels or direction bits.
- R5: A watched pin whose `dir_i` bit is 0 (output) is left out of the comparison and never sets the flag.
- R6: While a difference persists, `clr_flag_i` has no effect and `flag_o` stays 1.
- R7: A pulse on `rd_port_i` copies `pins_i` into the snapshot at that clock edge. After that, a `clr_flag_i` pulse clears `flag_o` at the next edge, provided no new difference has appeared.
- R8: If `clr_flag_i` and a difference occur in the same cycle, `flag_o` is 1 after that edge.
- R9: `irq_o` equals `flag_o` AND `int_en_i`, with no added latency.
- R10: `wake_o` equals `flag_o`, whatever the state of `int_en_i`.
- R11: The flag is sticky. It stays 1 after the pins return to their snapshot values and stays 1 until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 8 | Synchronized port pin levels |
| dir_i | input | 8 | Per-pin direction, 1 = input, 0 = output |
| rd_port_i | input | 1 | Port-read strobe; loads the snapshot |
| clr_flag_i | input | 1 | Flag-clear strobe |
| int_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt request (flag AND enable) |
| wake_o | output | 1 | Wake request (follows the flag) |

## Verification
Two events can fall in the same cycle. One is a flag clear. The other is a comparison difference, either a new pin edge or one that is still in place because no read has happened. The bench provokes both cases. It pulses the clear while a mismatched pin is held without a read, and it pulses the clear in the very cycle a watched pin toggles. In each case it expects the flag to read 1 after the edge. Only a clear that follows a snapshot read, with the pins matching, is expected to bring the flag to 0.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned IOC_PORT_W   = 8;
  localparam int unsigned IOC_WATCH_LO = 4;
  localparam int unsigned IOC_WATCH_HI = 7;

  function automatic logic [IOC_PORT_W-1:0] watch_mask(int unsigned lo, int unsigned hi);
    logic [IOC_PORT_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < IOC_PORT_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ioc_snapshot.sv
module ioc_snapshot #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pins_i,
  input  logic              rd_port_i,
  output logic [PORT_W-1:0] snap_o,
  output logic              valid_o
);
  logic [PORT_W-1:0] snap_q;
  logic              valid_q;

  // first edge after reset captures the pins, later edges only on a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (!valid_q || rd_port_i) snap_q <= pins_i;
      valid_q <= 1'b1;
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
  parameter int unsigned         PORT_W     = 8,
  parameter logic [PORT_W-1:0]   WATCH_MASK = 8'hF0
) (
  input  logic [PORT_W-1:0] pins_i,
  input  logic [PORT_W-1:0] snap_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              valid_i,
  output logic              mism_o
);
  logic [PORT_W-1:0] diff;

  assign diff   = (pins_i ^ snap_i) & dir_i & WATCH_MASK;
  assign mism_o = valid_i & (|diff);
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_change_ioc.sv
module port_change_ioc
  import ioc_pkg::*;
#(
  parameter int unsigned PORT_W   = IOC_PORT_W,
  parameter int unsigned WATCH_LO = IOC_WATCH_LO,
  parameter int unsigned WATCH_HI = IOC_WATCH_HI
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pins_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              rd_port_i,
  input  logic              clr_flag_i,
  input  logic              int_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [PORT_W-1:0] WatchMask = PORT_W'(watch_mask(WATCH_LO, WATCH_HI));

  logic [PORT_W-1:0] snap;
  logic              snap_valid;
  logic              mism_any;
  logic              flag;

  ioc_snapshot #(.PORT_W(PORT_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pins_i    (pins_i),
    .rd_port_i (rd_port_i),
    .snap_o    (snap),
    .valid_o   (snap_valid)
  );

  ioc_compare #(.PORT_W(PORT_W), .WATCH_MASK(WatchMask)) u_cmp (
    .pins_i  (pins_i),
    .snap_i  (snap),
    .dir_i   (dir_i),
    .valid_i (snap_valid),
    .mism_o  (mism_any)
  );

  ioc_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mism_any),
    .clr_i  (clr_flag_i),
    .flag_o (flag)
  );

  assign flag_o = flag;
  assign irq_o  = flag & int_en_i;
  assign wake_o = flag;
endmodule

// File: rtl/ioc_checker.sv
module ioc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_flag_i,
  input logic int_en_i,
  input logic mism_any,
  input logic flag_o,
  input logic irq_o,
  input logic wake_o
);
  AST_MISM_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism_any |=> flag_o); // R3

  AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism_any && clr_flag_i) |=> flag_o); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_flag_i) |=> flag_o); // R11

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mism_any && clr_flag_i) |=> !flag_o); // R7

  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(mism_any)); // R3

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |-> !irq_o); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R9

  AST_WAKE_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> wake_o); // R10
endmodule

bind port_change_ioc ioc_checker u_ioc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_flag_i (clr_flag_i),
  .int_en_i   (int_en_i),
  .mism_any   (mism_any),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o)
);

// File: tb/test_port_change_ioc.sv
module test_port_change_ioc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins_i = 8'h3C;
  logic [7:0] dir_i = 8'hFF;
  logic       rd_port_i = 1'b0;
  logic       clr_flag_i = 1'b0;
  logic       int_en_i = 1'b0;
  logic       flag_o, irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] snap_m;

  always #2 clk_i = ~clk_i;

  port_change_ioc i_port_change_ioc (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .dir_i(dir_i),
    .rd_port_i(rd_port_i), .clr_flag_i(clr_flag_i), .int_en_i(int_en_i),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] dir_pick(int k);
    case (k)
      0: return 8'hFF;
      1: return 8'h0F;
      2: return 8'hA5;
      default: return 8'h5A;
    endcase
  endfunction

  // read snapshot, then clear; leaves flag at 0
  task automatic read_and_clear();
    rd_port_i = 1'b1;
    tick();
    rd_port_i = 1'b0;
    snap_m = pins_i;
    clr_flag_i = 1'b1;
    tick();
    clr_flag_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 flag in reset", flag_o, 1'b0);
    chk("R1 irq in reset", irq_o, 1'b0);
    chk("R1 wake in reset", wake_o, 1'b0);
    rst_ni = 1'b1;
    tick();
    tick();
    snap_m = pins_i;
    chk("R2 steady after reset", flag_o, 1'b0);

    // near-exhaustive sweep: every change pattern under four direction sets
    for (int k = 0; k < 4; k++) begin
      for (int d = 1; d < 256; d++) begin
        logic exp;
        dir_i    = dir_pick(k);
        int_en_i = d[0];
        pins_i   = snap_m ^ 8'(d);
        exp      = |(8'(d) & dir_i & 8'hF0);
        tick();
        if (exp) chk("R3 watched input change", flag_o, 1'b1);
        else if ((8'(d) & 8'hF0) == 8'h00) chk("R4 low pins ignored", flag_o, 1'b0);
        else chk("R5 output pins ignored", flag_o, 1'b0);
        chk("R9 irq gating", irq_o, exp & int_en_i);
        chk("R10 wake follows flag", wake_o, exp);
        read_and_clear();
        chk("R7 clear after read", flag_o, 1'b0);
      end
    end

    // clear blocked while mismatch persists, then sticky after pins return
    dir_i = 8'hFF;
    int_en_i = 1'b0;
    pins_i = snap_m ^ 8'h40;
    tick();
    chk("R3 pin6 change", flag_o, 1'b1);
    chk("R10 wake without enable", wake_o, 1'b1);
    chk("R9 irq masked", irq_o, 1'b0);
    clr_flag_i = 1'b1;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R6 clear ignored during mismatch", flag_o, 1'b1);
    end
    clr_flag_i = 1'b0;
    pins_i = snap_m;
    tick();
    chk("R11 sticky after pins return", flag_o, 1'b1);
    clr_flag_i = 1'b1;
    tick();
    clr_flag_i = 1'b0;
    chk("R7 clear with no mismatch", flag_o, 1'b0);

    // clear and new change in the same cycle
    pins_i = snap_m ^ 8'h10;
    clr_flag_i = 1'b1;
    tick();
    clr_flag_i = 1'b0;
    chk("R8 clear loses to change", flag_o, 1'b1);
    read_and_clear();
    chk("R7 cleanup", flag_o, 1'b0);

    // reset with different pins: snapshot reloads on first edge
    rst_ni = 1'b0;
    pins_i = 8'hA0;
    tick();
    chk("R1 flag in second reset", flag_o, 1'b0);
    rst_ni = 1'b1;
    for (int n = 0; n < 3; n++) begin
      tick();
      chk("R2 reload after reset", flag_o, 1'b0);
    end
    pins_i = 8'h20;
    int_en_i = 1'b1;
    tick();
    chk("R3 pin7 change after reset", flag_o, 1'b1);
    chk("R9 irq enabled", irq_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule